// File: doc/BRIEF.md
# Deep-Sleep Entry and Wake Sequencer

This block moves a small processor core into a clock-stopped deep-sleep state and brings it back. A sleep request comes as a one-cycle wait-for-interrupt or wait-for-event pulse. It is honoured only when the deep-sleep control bit is set and the power-down control bit is clear. When honoured, the block gates the core clock. If the regulator-mode bit asks for it, the block also puts the voltage regulator into its low-power state.

A request is thrown away at once if any wake flag is already pending. If the peripheral bus is busy, entry waits until the access ends. While it waits, a wake or a pending flag cancels the entry. Once the core is asleep, only the wake lines that match the entry kind can wake it. Wake-up then steps through an optional regulator ramp delay and an oscillator settle delay. It forces the system clock select to the internal RC oscillator and ends with a one-cycle resume strobe.

Top module: `dsleep_seq`

## Requirements
- R1: After reset, `clk_gate_en`=1, `reg_lp_en`=0, `sysclk_sel`=0 and `resume`=0.
- R2: A pulse on `wfi_req` or `wfe_req` enters sleep (`clk_gate_en`=0 from the next cycle) only while `deep_en`=1 and `pdown`=0. Otherwise the pulse has no effect. When both pulses arrive together, wait-for-interrupt entry is taken.
- R3: If `pend_flags` is nonzero in the request cycle, the request is discarded and the clock stays on. A nonzero `pend_flags` while entry waits for the bus cancels the entry.
- R4: While `bus_busy`=1, entry is postponed and `clk_gate_en` stays 1. Sleep starts on the clock edge where `bus_busy` is seen low.
- R5: After wait-for-interrupt entry, the core wakes only when some bit of `irq_wake & irq_en` is 1. `evt_wake` is ignored.
- R6: After wait-for-event entry, the core wakes only when some bit of `evt_wake` is 1. `irq_wake` is ignored.
- R7: A matching wake line during the wait for the bus cancels the entry. The block returns to running with no resume strobe and no clock gating.
- R8: `reg_lp_en` is 1 exactly during the sleep cycles of an entry that sampled `lp_sel`=1 in its request cycle.
- R9: A wake forces `sysclk_sel` to 0 (internal RC) on the wake edge. `clk_sel_wr` loads `clk_sel_val` only while `clk_gate_en`=1 and is ignored otherwise.
- R10: After a wake, `clk_gate_en` stays 0 for REG_DLY cycles if low-power regulator mode was used, then for up to OSC_DLY settle cycles.
- R11: `osc_ready`=1 ends the oscillator settle wait at the next edge.
- R12: Every return from sleep gives exactly one cycle of `resume`=1, with `clk_gate_en`=1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wfi_req | input | 1 | Wait-for-interrupt request pulse |
| wfe_req | input | 1 | Wait-for-event request pulse |
| deep_en | input | 1 | Deep-sleep select bit |
| pdown | input | 1 | Power-down select bit (blocks this path) |
| lp_sel | input | 1 | Regulator low-power during sleep |
| bus_busy | input | 1 | Peripheral bus access in flight |
| pend_flags | input | NPEND | Pending wake flags |
| irq_wake | input | NLINE | Wake lines in interrupt mode |
| irq_en | input | NLINE | Interrupt enables for those lines |
| evt_wake | input | NLINE | Wake lines in event mode |
| osc_ready | input | 1 | Internal RC oscillator ready |
| clk_sel_wr | input | 1 | Write strobe for clock select |
| clk_sel_val | input | SELW | New clock select value |
| clk_gate_en | output | 1 | Core clock enable |
| reg_lp_en | output | 1 | Regulator low-power enable |
| sysclk_sel | output | SELW | System clock select, 0 = internal RC |
| resume | output | 1 | One-cycle resume strobe |

## Verification
Sleep entry is tried against disabled control bits, a pending flag, a busy bus, and a busy bus followed by a wake or a flag. These cases separate a discarded request, a postponed entry and a cancelled entry. Each wake kind is driven with the wrong line group first and with a masked interrupt line, then with the right line. This shows that the wake source follows the entry kind. Wakes are run with and without low-power regulator mode, and with an early oscillator-ready. This separates the two delay stages and the early settle exit. A behavioural model predicts every output on every cycle.

// File: rtl/dsleep_seq.sv
module dsleep_seq #(
  parameter int NPEND   = 4,
  parameter int NLINE   = 8,
  parameter int REG_DLY = 16,
  parameter int OSC_DLY = 8,
  parameter int SELW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wfi_req,
  input  logic             wfe_req,
  input  logic             deep_en,
  input  logic             pdown,
  input  logic             lp_sel,
  input  logic             bus_busy,
  input  logic [NPEND-1:0] pend_flags,
  input  logic [NLINE-1:0] irq_wake,
  input  logic [NLINE-1:0] irq_en,
  input  logic [NLINE-1:0] evt_wake,
  input  logic             osc_ready,
  input  logic             clk_sel_wr,
  input  logic [SELW-1:0]  clk_sel_val,
  output logic             clk_gate_en,
  output logic             reg_lp_en,
  output logic [SELW-1:0]  sysclk_sel,
  output logic             resume
);
  localparam int MAXD = (REG_DLY > OSC_DLY) ? REG_DLY : OSC_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  typedef enum logic [2:0] {RUN, WAIT_BUS, SLEEP, REG_WAKE, OSC_WAKE, RESUME} st_t;
  st_t st, nx;
  logic evt_mode, lp_q;
  logic [CW-1:0] cnt;

  wire req      = (wfi_req | wfe_req) & deep_en & ~pdown;
  wire pend     = |pend_flags;
  wire wake     = evt_mode ? |evt_wake : |(irq_wake & irq_en);
  wire reg_done = (cnt == CW'(REG_DLY - 1));
  wire osc_done = osc_ready | (cnt == CW'(OSC_DLY - 1));

  always_comb begin
    nx = st;
    case (st)
      RUN:      if (req && !pend) nx = bus_busy ? WAIT_BUS : SLEEP;
      WAIT_BUS: if (wake || pend) nx = RUN;
                else if (!bus_busy) nx = SLEEP;
      SLEEP:    if (wake) nx = lp_q ? REG_WAKE : OSC_WAKE;
      REG_WAKE: if (reg_done) nx = OSC_WAKE;
      OSC_WAKE: if (osc_done) nx = RESUME;
      RESUME:   nx = RUN;
      default:  nx = RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RUN;
      cnt        <= '0;
      evt_mode   <= 1'b0;
      lp_q       <= 1'b0;
      sysclk_sel <= '0;
    end else begin
      st  <= nx;
      cnt <= (st != nx) ? '0 : cnt + CW'(1);
      if (st == RUN && req) begin
        evt_mode <= ~wfi_req;
        lp_q     <= lp_sel;
      end
      if (st == SLEEP && wake) sysclk_sel <= '0;
      else if (clk_sel_wr && clk_gate_en) sysclk_sel <= clk_sel_val;
    end
  end

  assign clk_gate_en = !(st == SLEEP || st == REG_WAKE || st == OSC_WAKE);
  assign reg_lp_en   = (st == SLEEP) && lp_q;
  assign resume      = (st == RESUME);
endmodule

// File: rtl/dsleep_seq_chk.sv
module dsleep_seq_chk #(
  parameter int NPEND = 4,
  parameter int SELW  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPEND-1:0] pend_flags,
  input logic             bus_busy,
  input logic             clk_gate_en,
  input logic             reg_lp_en,
  input logic [SELW-1:0]  sysclk_sel,
  input logic             resume
);
  p_pend_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_en && |pend_flags) |=> clk_gate_en);
  p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_en && bus_busy) |=> clk_gate_en);
  p_lp_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_lp_en |-> !clk_gate_en);
  p_rc_on_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate_en) |-> (resume && sysclk_sel == '0));
  p_resume_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  p_resume_clk_on_r12: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> clk_gate_en);
endmodule

bind dsleep_seq dsleep_seq_chk #(.NPEND(NPEND), .SELW(SELW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_flags(pend_flags), .bus_busy(bus_busy),
  .clk_gate_en(clk_gate_en), .reg_lp_en(reg_lp_en),
  .sysclk_sel(sysclk_sel), .resume(resume));

// File: tb/dsleep_seq_bench.sv
module dsleep_seq_bench;
  localparam int NPEND = 4, NLINE = 8, REG_DLY = 16, OSC_DLY = 8, SELW = 2;

  logic clk = 0, rst_n = 0;
  logic wfi_req = 0, wfe_req = 0, deep_en = 0, pdown = 0, lp_sel = 0, bus_busy = 0;
  logic [NPEND-1:0] pend_flags = '0;
  logic [NLINE-1:0] irq_wake = '0, irq_en = '0, evt_wake = '0;
  logic osc_ready = 0, clk_sel_wr = 0;
  logic [SELW-1:0] clk_sel_val = '0;
  logic clk_gate_en, reg_lp_en, resume;
  logic [SELW-1:0] sysclk_sel;

  int vectors = 0, miscompares = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  dsleep_seq #(.NPEND(NPEND), .NLINE(NLINE), .REG_DLY(REG_DLY), .OSC_DLY(OSC_DLY), .SELW(SELW))
  u_dsleep_seq (.*);

  // reference model: 0 run, 1 bus wait, 2 asleep, 3 regulator ramp, 4 osc settle, 5 resume
  int ph = 0, tmr = 0, m_sel = 0;
  bit m_evt = 0, m_lp = 0;

  function automatic bit m_wake();
    return m_evt ? (evt_wake != 0) : ((irq_wake & irq_en) != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; tmr = 0; m_sel = 0; m_evt = 0; m_lp = 0;
    end else begin
      if (ph == 2 && m_wake()) m_sel = 0;
      else if (clk_sel_wr && !(ph >= 2 && ph <= 4)) m_sel = int'(clk_sel_val);
      case (ph)
        0: if ((wfi_req || wfe_req) && deep_en && !pdown) begin
             m_evt = !wfi_req; m_lp = lp_sel;
             if (pend_flags == 0) ph = bus_busy ? 1 : 2;
           end
        1: if (m_wake() || pend_flags != 0) ph = 0;
           else if (!bus_busy) ph = 2;
        2: if (m_wake()) begin
             if (m_lp) begin ph = 3; tmr = REG_DLY; end
             else begin ph = 4; tmr = OSC_DLY; end
           end
        3: begin tmr--; if (tmr == 0) begin ph = 4; tmr = OSC_DLY; end end
        4: begin tmr--; if (osc_ready || tmr == 0) ph = 5; end
        default: ph = 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check("R10 clk_gate_en", int'(clk_gate_en), int'(!(ph >= 2 && ph <= 4)));
    check("R8 reg_lp_en", int'(reg_lp_en), int'(ph == 2 && m_lp));
    check("R9 sysclk_sel", int'(sysclk_sel), m_sel);
    check("R12 resume", int'(resume), int'(ph == 5));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit use_wfe);
    if (use_wfe) wfe_req = 1; else wfi_req = 1;
    tick(1);
    wfi_req = 0; wfe_req = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    check("R1 gate", int'(clk_gate_en), 1);
    check("R1 lp", int'(reg_lp_en), 0);
    check("R1 sel", int'(sysclk_sel), 0);
    check("R1 resume", int'(resume), 0);
    model_on = 1;

    clk_sel_wr = 1; clk_sel_val = 2; tick(1); clk_sel_wr = 0; tick(1);

    // R2: disabled requests
    pulse(0); tick(1); check("R2 deep_en low", int'(clk_gate_en), 1);
    deep_en = 1; pdown = 1;
    pulse(1); tick(1); check("R2 pdown high", int'(clk_gate_en), 1);
    pdown = 0;

    // R3: pending flag discards request
    pend_flags = 4'b0100; pulse(0); tick(1);
    check("R3 refused", int'(clk_gate_en), 1);
    pend_flags = '0;

    // WFI entry, low-power regulator
    lp_sel = 1; pulse(0); lp_sel = 0;
    check("R2 entered", int'(clk_gate_en), 0);
    clk_sel_wr = 1; clk_sel_val = 3; tick(1); clk_sel_wr = 0;
    evt_wake = '1; tick(2); evt_wake = '0;
    check("R5 evt ignored", int'(clk_gate_en), 0);
    irq_wake = 8'h01; tick(2);
    check("R5 masked irq", int'(clk_gate_en), 0);
    irq_en = 8'h01; tick(1); irq_wake = '0; irq_en = '0;
    check("R9 rc forced", int'(sysclk_sel), 0);
    tick(REG_DLY + OSC_DLY + 2);
    check("R12 back running", int'(clk_gate_en), 1);

    // WFE entry, regulator on, early oscillator ready
    clk_sel_wr = 1; clk_sel_val = 1; tick(1); clk_sel_wr = 0;
    pulse(1);
    irq_wake = '1; irq_en = '1; tick(2); irq_wake = '0; irq_en = '0;
    check("R6 irq ignored", int'(clk_gate_en), 0);
    evt_wake = 8'h80; osc_ready = 1; tick(1); evt_wake = '0;
    tick(1);
    check("R11 early settle", int'(resume), 1);
    osc_ready = 0; tick(2);

    // R4: bus busy postpones entry
    bus_busy = 1; pulse(0); tick(2);
    check("R4 postponed", int'(clk_gate_en), 1);
    bus_busy = 0; tick(1);
    check("R4 entered after bus", int'(clk_gate_en), 0);
    irq_wake = 8'h10; irq_en = 8'h10; tick(1); irq_wake = '0; irq_en = '0;
    tick(OSC_DLY + 2);

    // R7: wake during bus wait aborts
    bus_busy = 1; pulse(0); tick(1);
    irq_wake = 8'h02; irq_en = 8'h02; tick(1); irq_wake = '0; irq_en = '0;
    bus_busy = 0; tick(2);
    check("R7 abort gate", int'(clk_gate_en), 1);
    check("R7 no resume", int'(resume), 0);

    // R3: pending flag during bus wait aborts
    bus_busy = 1; pulse(1); tick(1);
    pend_flags = 4'b0001; tick(1); pend_flags = '0; bus_busy = 0; tick(2);
    check("R3 abort in bus wait", int'(clk_gate_en), 1);

    // R2: simultaneous requests take WFI
    wfi_req = 1; wfe_req = 1; tick(1); wfi_req = 0; wfe_req = 0;
    evt_wake = '1; tick(2); evt_wake = '0;
    check("R2 wfi priority", int'(clk_gate_en), 0);
    irq_wake = 8'h04; irq_en = 8'h04; tick(1); irq_wake = '0; irq_en = '0;
    tick(OSC_DLY + 3);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule